// File: doc/BRIEF.md
# Conditional Branch Execution Unit

This unit resolves a short relative branch. A `start` strobe captures a 16-bit instruction word, a 4-bit condition-flag nibble and the current program counter. The unit selects one of seven branch conditions from the upper byte of the instruction and tests it against the captured flags. It then reports whether the branch is taken. For a taken branch, it forms the target through one shared ALU over several clocked steps: it loads the displacement, sign-extends it, shifts it left by one, and adds it to the PC. A one-cycle `done` pulse marks the end of every request. After that pulse, `pc_out`, `taken` and `illegal` hold their values until the next accepted `start`.

The controller is a state machine with these states:
- `S_IDLE`: waits for `start`.
- `S_DECODE`: performs the condition range compare and the flag test.
- `S_LOAD`: moves the displacement byte into a temporary register.
- `S_SEXT`: sign-extends the temporary register.
- `S_SHIFT`: doubles the temporary register.
- `S_ADD`: writes PC + temporary into the PC register.
- `S_DONE`: raises `done` for one cycle.

Its transitions are:
- IDLE→DECODE on `start`.
- DECODE→LOAD when the branch is taken.
- DECODE→DONE when the branch is not taken or the opcode is illegal.
- LOAD→SEXT→SHIFT→ADD→DONE, one step per cycle.
- DONE→IDLE.

Top module: `cond_branch_unit`

## Requirements
- R1: The opcode is `instr[15:8]`. It is compared in ascending order against the lower bound of each following branch kind. The values 0x01 through 0x07 select BR, BNE, BEQ, BGE, BLT, BGT and BLE, in that order.
- R2: BR (opcode 0x01) is taken for every flag value.
- R3: The flags are ordered {N,Z,V,C}, so N is `flags[3]`, Z is `flags[2]` and V is `flags[1]`. BNE is taken when Z=0, and BEQ is taken when Z=1.
- R4: BGE is taken when N xor V is 0, and BLT is taken when N xor V is 1.
- R5: BGT is taken when Z=0 and N equals V. BLE is taken when Z=1 or N differs from V.
- R6: On a taken branch, `pc_out` becomes `pc_in` plus twice the sign-extended `instr[7:0]`, modulo 2^16. A displacement of 0x80 or above branches backward.
- R7: On a branch that is not taken, `pc_out` equals the captured `pc_in`. `done` rises 2 cycles after the clock edge that accepts `start`, counting that edge as the first.
- R8: On a taken branch, `done` rises 6 edges after acceptance, counted in the same way. In every case `done` is high for exactly one cycle.
- R9: An opcode of 0x00, or of 0x08 and above, sets `illegal`, leaves `taken` at 0 and keeps `pc_out` equal to `pc_in`. Its `done` timing is the same as in R7.
- R10: After reset, `done`, `taken` and `illegal` are 0 and `pc_out` is 0.
- R11: A `start` that arrives while a request is in progress is ignored. The result belongs to the request already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a request; sampled only when idle |
| instr | input | 16 | Branch instruction word |
| flags | input | 4 | Condition flags {N,Z,V,C} |
| pc_in | input | 16 | Current program counter |
| pc_out | output | 16 | Resulting program counter |
| taken | output | 1 | Branch was taken |
| illegal | output | 1 | Opcode is outside the branch range |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default widths: a 16-bit word, an 8-bit displacement and an opcode base of 1. These values bring within reach both displacement extremes, 0x7F and 0x80, and a PC near 0xFFFF, so the modulo-2^16 wrap and backward branches are exercised directly. Both ends of the opcode range, 0x00 and 0x08, are reachable, along with 0xFF. With these values the flag patterns can also be swept exhaustively for every condition.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_LOAD,
        S_SEXT,
        S_SHIFT,
        S_ADD,
        S_DONE
    } cbu_state_t;

    typedef enum logic [2:0] {
        K_BR  = 3'd0,
        K_BNE = 3'd1,
        K_BEQ = 3'd2,
        K_BGE = 3'd3,
        K_BLT = 3'd4,
        K_BGT = 3'd5,
        K_BLE = 3'd6
    } cbu_kind_t;

    typedef enum logic [1:0] {
        OP_PASS,
        OP_SEXT,
        OP_SHL,
        OP_ADD
    } cbu_aluop_t;

    localparam int NUM_KINDS = 7;
    localparam int FLAG_N    = 3;
    localparam int FLAG_Z    = 2;
    localparam int FLAG_V    = 1;

endpackage

// File: rtl/cbu_cond_decode.sv
module cbu_cond_decode
    import cbu_pkg::*;
#(
    parameter int OPC_W    = 8,
    parameter int OPC_BASE = 1
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [3:0]       flg,
    output logic             legal,
    output logic             pass
);

    cbu_kind_t kind;
    logic      found;
    logic      f_n, f_z, f_v;

    assign f_n = flg[FLAG_N];
    assign f_z = flg[FLAG_Z];
    assign f_v = flg[FLAG_V];

    // ordered range compare: first upper bound the opcode falls below wins
    always_comb begin
        found = 1'b0;
        kind  = K_BR;
        if (opc >= OPC_W'(OPC_BASE)) begin
            for (int k = 0; k < NUM_KINDS; k++) begin
                if (!found && (opc < OPC_W'(OPC_BASE + k + 1))) begin
                    found = 1'b1;
                    kind  = cbu_kind_t'(3'(k));
                end
            end
        end
        legal = found;
    end

    always_comb begin
        unique case (kind)
            K_BR:    pass = 1'b1;
            K_BNE:   pass = !f_z;
            K_BEQ:   pass = f_z;
            K_BGE:   pass = !(f_n ^ f_v);
            K_BLT:   pass = f_n ^ f_v;
            K_BGT:   pass = !f_z && (f_n == f_v);
            K_BLE:   pass = f_z || (f_n != f_v);
            default: pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbu_alu.sv
module cbu_alu
    import cbu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DISP_W = 8
) (
    input  cbu_aluop_t        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam int EXT_W = DATA_W - DISP_W;

    always_comb begin
        unique case (op)
            OP_PASS: y = a;
            OP_SEXT: y = {{EXT_W{a[DISP_W-1]}}, a[DISP_W-1:0]};
            OP_SHL:  y = {a[DATA_W-2:0], 1'b0};
            OP_ADD:  y = a + b;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int DISP_W   = 8,
    parameter int OPC_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr,
    input  logic [3:0]        flags,
    input  logic [15:0]       pc_in,
    output logic [15:0]       pc_out,
    output logic              taken,
    output logic              illegal,
    output logic              done
);

    localparam int OPC_W = DATA_W - DISP_W;

    cbu_state_t        state_q, state_d;
    logic [DATA_W-1:0] ir_q, pc_q, tmp_q;
    logic [3:0]        flg_q;
    logic              taken_q, illegal_q;
    logic              busy;
    logic              legal, pass;
    cbu_aluop_t        alu_op;
    logic [DATA_W-1:0] alu_a, alu_b, alu_y;

    cbu_cond_decode #(
        .OPC_W    (OPC_W),
        .OPC_BASE (OPC_BASE)
    ) dec_i (
        .opc   (ir_q[DATA_W-1:DISP_W]),
        .flg   (flg_q),
        .legal (legal),
        .pass  (pass)
    );

    cbu_alu #(
        .DATA_W (DATA_W),
        .DISP_W (DISP_W)
    ) alu_i (
        .op (alu_op),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_DECODE;
            S_DECODE: state_d = (legal && pass) ? S_LOAD : S_DONE;
            S_LOAD:   state_d = S_SEXT;
            S_SEXT:   state_d = S_SHIFT;
            S_SHIFT:  state_d = S_ADD;
            S_ADD:    state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // shared ALU operand steering
    always_comb begin
        alu_op = OP_PASS;
        alu_a  = tmp_q;
        alu_b  = '0;
        unique case (state_q)
            S_LOAD:  begin alu_op = OP_PASS; alu_a = {{OPC_W{1'b0}}, ir_q[DISP_W-1:0]}; end
            S_SEXT:  alu_op = OP_SEXT;
            S_SHIFT: alu_op = OP_SHL;
            S_ADD:   begin alu_op = OP_ADD; alu_a = pc_q; alu_b = tmp_q; end
            default: ;
        endcase
    end

    // datapath and registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q      <= '0;
            flg_q     <= '0;
            pc_q      <= '0;
            tmp_q     <= '0;
            taken_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    ir_q      <= instr;
                    flg_q     <= flags;
                    pc_q      <= pc_in;
                    taken_q   <= 1'b0;
                    illegal_q <= 1'b0;
                end
                S_DECODE: begin
                    illegal_q <= !legal;
                    taken_q   <= legal && pass;
                end
                S_LOAD, S_SEXT, S_SHIFT: tmp_q <= alu_y;
                S_ADD:   pc_q <= alu_y;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != S_IDLE);
        done    = (state_q == S_DONE);
        taken   = taken_q;
        illegal = illegal_q;
        pc_out  = pc_q;
    end

endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
    parameter int DATA_W = 16,
    parameter int DISP_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [15:0] instr,
    input logic [15:0] pc_in,
    input logic        busy,
    input logic        done,
    input logic        taken,
    input logic        illegal,
    input logic [15:0] pc_out
);

    logic [15:0]       pc_cap;
    logic [DISP_W-1:0] disp_cap;
    logic [15:0]       offs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_cap   <= '0;
            disp_cap <= '0;
        end else if (start && !busy) begin
            pc_cap   <= pc_in;
            disp_cap <= instr[DISP_W-1:0];
        end
    end

    always_comb offs = 16'($signed(disp_cap)) <<< 1;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_in_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R9
    illegal_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !taken);

    // R7
    hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (pc_out == pc_cap));

    // R6
    target_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && taken) |-> (pc_out == 16'(pc_cap + offs)));

endmodule

bind cond_branch_unit cbu_checker #(
    .DATA_W (DATA_W),
    .DISP_W (DISP_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .instr   (instr),
    .pc_in   (pc_in),
    .busy    (busy),
    .done    (done),
    .taken   (taken),
    .illegal (illegal),
    .pc_out  (pc_out)
);

// File: tb/cond_branch_unit_tb_top.sv
module cond_branch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [3:0]  flags = '0;
    logic [15:0] pc_in = '0;
    logic [15:0] pc_out;
    logic        taken, illegal, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cond_branch_unit dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .instr   (instr),
        .flags   (flags),
        .pc_in   (pc_in),
        .pc_out  (pc_out),
        .taken   (taken),
        .illegal (illegal),
        .done    (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected decision from the rules: flags {N,Z,V,C}
    function automatic bit model_take(input logic [7:0] op, input logic [3:0] f);
        bit n = f[3], z = f[2], v = f[1];
        case (op)
            8'h01:   return 1'b1;
            8'h02:   return !z;
            8'h03:   return z;
            8'h04:   return n == v;
            8'h05:   return n != v;
            8'h06:   return !z && (n == v);
            8'h07:   return z || (n != v);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] model_target(input logic [15:0] pc, input logic [7:0] d);
        logic [15:0] ext = {{8{d[7]}}, d};
        return pc + (ext * 16'd2);
    endfunction

    task automatic run_one(input string req, input logic [7:0] op, input logic [7:0] d,
                           input logic [3:0] f, input logic [15:0] pc);
        int n;
        bit legal = (op >= 8'h01) && (op <= 8'h07);
        bit exp_t = legal && model_take(op, f);
        logic [15:0] exp_pc = exp_t ? model_target(pc, d) : pc;
        int exp_lat = exp_t ? 6 : 2;
        @(negedge clk);
        instr = {op, d}; flags = f; pc_in = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == exp_lat, req, "latency", n, exp_lat);
        check(taken == exp_t, req, "taken", int'(taken), int'(exp_t));
        check(illegal == !legal, req, "illegal", int'(illegal), int'(!legal));
        check(pc_out == exp_pc, req, "pc_out", int'(pc_out), int'(exp_pc));
        @(negedge clk);
        check(done == 1'b0, "R8", "done pulse width", int'(done), 0);
    endtask

    task automatic t_reset;
        check(done == 1'b0, "R10", "done", int'(done), 0);
        check(taken == 1'b0, "R10", "taken", int'(taken), 0);
        check(illegal == 1'b0, "R10", "illegal", int'(illegal), 0);
        check(pc_out == 16'h0, "R10", "pc_out", int'(pc_out), 0);
    endtask

    // R1 R2 R3 R4 R5: every condition against every N/Z/V pattern
    task automatic t_conditions;
        string tag [8] = '{"R1", "R2", "R3", "R3", "R4", "R4", "R5", "R5"};
        for (int op = 1; op <= 7; op++) begin
            for (int f = 0; f < 16; f += 2) begin
                run_one(tag[op], 8'(op), 8'h05, 4'(f), 16'h1000);
            end
        end
    endtask

    // R6: displacement extremes and wrap
    task automatic t_targets;
        run_one("R6", 8'h01, 8'h7F, 4'h0, 16'h2000);
        run_one("R6", 8'h01, 8'h80, 4'h0, 16'h2000);
        run_one("R6", 8'h01, 8'hFF, 4'h0, 16'h0000);
        run_one("R6", 8'h01, 8'h7F, 4'h0, 16'hFFF0);
        run_one("R6", 8'h03, 8'h00, 4'h4, 16'h1234);
    endtask

    // R7: untaken keeps pc
    task automatic t_untaken;
        run_one("R7", 8'h02, 8'h40, 4'h4, 16'hBEEF);
        run_one("R7", 8'h06, 8'h80, 4'h8, 16'h0102);
    endtask

    // R9: out-of-range opcodes
    task automatic t_illegal;
        run_one("R9", 8'h00, 8'h10, 4'h0, 16'h5555);
        run_one("R9", 8'h08, 8'h10, 4'h0, 16'h6666);
        run_one("R9", 8'hFF, 8'h10, 4'hF, 16'h7777);
    endtask

    // R11: second start during a request is ignored
    task automatic t_busy_ignore;
        int n;
        logic [15:0] exp_pc = model_target(16'h0400, 8'h10);
        @(negedge clk);
        instr = 16'h0110; flags = 4'h0; pc_in = 16'h0400; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        instr = 16'h00AA; pc_in = 16'h9999; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 3;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == 6, "R11", "latency", n, 6);
        check(pc_out == exp_pc, "R11", "pc_out", int'(pc_out), int'(exp_pc));
        check(illegal == 1'b0, "R11", "illegal", int'(illegal), 0);
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R11", "no extra done", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_conditions();
        t_targets();
        t_untaken();
        t_illegal();
        t_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule